// File: doc/BRIEF.md
# Timer with Asynchronous Count-Write Handshake

This block is a 16-bit timer peripheral on a simple synchronous register bus. It has four registers: control, count, period and status. The counter advances on prescaled ticks and has three tick sources. The first is the bus clock. The second is an external clock that is sampled into the bus domain. The third is that same external clock used directly as the counter clock. Whenever the counter equals the period value on a tick, it returns to zero and raises a sticky match flag.

The counter can run directly from the external clock. In that mode a bus write to the count register cannot reach the counter at once. The block holds the written value and hands it to the external-clock domain with a toggle request. A second toggle comes back as the acknowledge. The control register shows a write-in-progress flag until the value has been applied. A lockout bit decides what happens to further count writes while one is pending. With the lockout set they are dropped. With it clear they are accepted, and the most recent value wins.

Two controls stop counting for system states: freeze-in-debug, and stop-while-idle. The freeze control can only be set while the debug input is high.

Top module: `hs_timer`

## Requirements
- R1: After reset, control reads 0x0000_0000, count reads 0, period reads 0x0000_FFFF, status reads 0 and `match_o` is low.
- R2: Control bits 31:16, 10:6, 3 and 0 always read 0 and ignore writes; bit 11 (write-in-progress) ignores writes. Writing all ones with the debug input low reads back 0x0000_B036.
- R3: Control bit 14 (freeze) takes a written value only while `dbg_i` is high and is cleared on the first clock with `dbg_i` low; while it is set and `dbg_i` is high the count does not move.
- R4: With control bit 13 (stop-in-idle) set, the count does not move while `idle_i` is high; with it clear, `idle_i` has no effect.
- R5: Control bit 15 enables counting. With bits 1 and 2 clear, the count advances by one per prescaled tick of the bus clock, and the prescaler restarts on every control write. With bit 15 clear the count holds.
- R6: On a tick with count equal to period, the count becomes 0 and status bit 0 (`match_o`) is set. It stays set until the bus writes 1 to status bit 0. After k bus clocks from enabling at count 0, the count is k mod (period+1).
- R7: Control bits 5:4 select the prescale ratio: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256 tick sources per count.
- R8: With control bits 1 and 2 both set, each rising edge of `ext_clk_i` is a tick source, detected after a two-flop synchroniser in the bus domain.
- R9: With bit 1 set and bit 2 clear (asynchronous mode), a count write sets control bit 11 at once. The bit stays set, and the count keeps its old value, until the value has been applied on `ext_clk_i` edges. Then the count reads the written value and bit 11 reads 0.
- R10: In asynchronous mode with control bit 12 (write lockout) set, a count write made while bit 11 is set is dropped.
- R11: In asynchronous mode with bit 12 clear, count writes made while one is pending are accepted, and the value written last is the one the count ends with.
- R12: Outside asynchronous mode a count write loads the count on the same bus clock, bit 11 reads 0, and bit 12 has no effect on back-to-back writes.
- R13: In asynchronous mode with bit 15 set, the count advances once per `ext_clk_i` rising edge (prescale 1), and a period match there also sets the status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| ext_clk_i | input | 1 | External timer clock |
| dbg_i | input | 1 | Processor is in debug mode |
| idle_i | input | 1 | System is in idle state |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | 2 | Register address: 0 control, 1 count, 2 period, 3 status |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, combinational from the address |
| match_o | output | 1 | Sticky period-match flag |

## Verification
The bench builds the timer with its default widths: a 16-bit counter and an 8-bit prescaler. With these widths the full /256 ratio can be reached in a few hundred clocks, and every prescale setting is swept at and around its tick boundaries. Periods 0 to 6 are each swept over 21 run lengths, which covers the zero-period case and several wraps. The external clock is a slow signal that the bench drives by hand. The bench can therefore hold a count write pending for as long as it likes, issue lockout and back-to-back writes into that window, and then release edges one at a time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned B_ON    = 15;
  localparam int unsigned B_FRZ   = 14;
  localparam int unsigned B_SIDL  = 13;
  localparam int unsigned B_WDIS  = 12;
  localparam int unsigned B_TWIP  = 11;
  localparam int unsigned B_PS_LO = 4;
  localparam int unsigned B_SYNC  = 2;
  localparam int unsigned B_CS    = 1;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_COUNT  = 2'd1,
    A_PERIOD = 2'd2,
    A_STAT   = 2'd3
  } reg_addr_e;

  // tick sources needed for one count step
  function automatic int unsigned presc_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      2'd2:    return 64;
      default: return 256;
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync2.sv
module tmr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       src_en,
  input  logic [1:0] ckps,
  output logic       tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = PW'(presc_div(ckps) - 1);
  assign tick = run && src_en && (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_q <= '0;
    else if (clr)           pre_q <= '0;
    else if (run && src_en) pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
  end

  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (pre_q == '0)); // R7
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  assign hit = tick && !ld && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (hit)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0)); // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && !hit) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt)); // R3
endmodule

// File: rtl/tmr_async_wr.sv
module tmr_async_wr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          wdis,
  input  logic [CW-1:0] wdata,
  output logic          busy,
  input  logic          eclk,
  output logic          e_ld,
  output logic [CW-1:0] e_val
);
  logic          req_q, busy_q, nxt_v;
  logic [CW-1:0] hold_q, nxt_q;
  logic          req_es, ack_q, ack_bs;
  logic          ack_seen, take;

  assign ack_seen = busy_q && (ack_bs == req_q);
  assign take     = wr && !(busy_q && wdis);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      nxt_v  <= 1'b0;
      hold_q <= '0;
      nxt_q  <= '0;
    end else if (!busy_q) begin
      if (wr) begin
        hold_q <= wdata;
        req_q  <= ~req_q;
        busy_q <= 1'b1;
      end
    end else if (ack_seen) begin
      if (take || nxt_v) begin
        hold_q <= take ? wdata : nxt_q;
        req_q  <= ~req_q;
        nxt_v  <= 1'b0;
      end else begin
        busy_q <= 1'b0;
      end
    end else if (take) begin
      nxt_q <= wdata;
      nxt_v <= 1'b1;
    end
  end

  // timer-clock side: detect request toggle, answer with same level
  tmr_sync2 #(.W(1)) u_req_sync (.clk(eclk), .rst_n(rst_n), .d(req_q), .q(req_es));

  always_ff @(posedge eclk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req_es;
  end

  assign e_ld  = (req_es != ack_q);
  assign e_val = hold_q;

  tmr_sync2 #(.W(1)) u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_q), .q(ack_bs));

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_seen) |=> $stable(hold_q)); // R9
  AST_REQ_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_q) |-> $past(!busy_q || ack_seen)); // R9
  AST_LOCKOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wdis && wr && !nxt_v) |=> !nxt_v); // R10
endmodule

// File: rtl/hs_timer.sv
module hs_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_clk_i,
  input  logic        dbg_i,
  input  logic        idle_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        match_o
);
  localparam int PADW = BUS_W - CNT_W;

  logic             on_q, frz_q, sidl_q, wdis_q, sync_q, cs_q;
  logic [1:0]       ckps_q;
  logic [CNT_W-1:0] period_q;
  logic             flag_q;

  logic wr_ctrl, wr_cnt, wr_per, clr_flag;
  logic async_mode, run_b;
  logic ext_s, ext_d, ext_rise;
  logic tick_b, hit_b;
  logic [CNT_W-1:0] cnt_b;
  logic busy;
  logic e_ld;
  logic [CNT_W-1:0] e_val;
  logic run_e, tick_e, hit_e;
  logic [CNT_W-1:0] cnt_e;
  logic mt_e, mt_s, mt_d, hit_x;
  logic [31:0] ctrl_rd;

  assign wr_ctrl  = bus_sel_i && bus_we_i && (bus_addr_i == A_CTRL);
  assign wr_cnt   = bus_sel_i && bus_we_i && (bus_addr_i == A_COUNT);
  assign wr_per   = bus_sel_i && bus_we_i && (bus_addr_i == A_PERIOD);
  assign clr_flag = bus_sel_i && bus_we_i && (bus_addr_i == A_STAT) && bus_wdata_i[0];

  assign async_mode = cs_q && !sync_q;
  assign run_b      = on_q && !(frz_q && dbg_i) && !(sidl_q && idle_i);

  // control and period registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q <= 1'b0; sidl_q <= 1'b0; wdis_q <= 1'b0;
      sync_q <= 1'b0; cs_q <= 1'b0; ckps_q <= 2'b00;
      period_q <= '1;
    end else begin
      if (wr_ctrl) begin
        on_q   <= bus_wdata_i[B_ON];
        sidl_q <= bus_wdata_i[B_SIDL];
        wdis_q <= bus_wdata_i[B_WDIS];
        sync_q <= bus_wdata_i[B_SYNC];
        cs_q   <= bus_wdata_i[B_CS];
        ckps_q <= bus_wdata_i[B_PS_LO +: 2];
      end
      if (wr_per) period_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               frz_q <= 1'b0;
    else if (!dbg_i)           frz_q <= 1'b0;
    else if (wr_ctrl)          frz_q <= bus_wdata_i[B_FRZ];
  end

  // bus-domain counting path
  tmr_sync2 #(.W(1)) u_ext_sync (.clk(clk_i), .rst_n(rst_ni), .d(ext_clk_i), .q(ext_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d <= 1'b0;
    else         ext_d <= ext_s;
  end
  assign ext_rise = ext_s && !ext_d;

  tmr_prescaler #(.PW(PRE_W)) u_pre_b (
    .clk(clk_i), .rst_n(rst_ni), .clr(wr_ctrl),
    .run(run_b && !async_mode), .src_en(cs_q ? ext_rise : 1'b1),
    .ckps(ckps_q), .tick(tick_b)
  );

  tmr_count_core #(.CW(CNT_W)) u_cnt_b (
    .clk(clk_i), .rst_n(rst_ni), .tick(tick_b),
    .ld(wr_cnt && !async_mode), .ld_val(bus_wdata_i[CNT_W-1:0]),
    .period(period_q), .cnt(cnt_b), .hit(hit_b)
  );

  // write crossing into the external-clock domain
  tmr_async_wr #(.CW(CNT_W)) u_xwr (
    .clk(clk_i), .rst_n(rst_ni), .wr(wr_cnt && async_mode), .wdis(wdis_q),
    .wdata(bus_wdata_i[CNT_W-1:0]), .busy(busy),
    .eclk(ext_clk_i), .e_ld(e_ld), .e_val(e_val)
  );

  // external-clock-domain counting path
  tmr_sync2 #(.W(1)) u_run_sync (.clk(ext_clk_i), .rst_n(rst_ni),
    .d(run_b && async_mode), .q(run_e));

  tmr_prescaler #(.PW(PRE_W)) u_pre_e (
    .clk(ext_clk_i), .rst_n(rst_ni), .clr(!run_e), .run(run_e),
    .src_en(1'b1), .ckps(ckps_q), .tick(tick_e)
  );

  tmr_count_core #(.CW(CNT_W)) u_cnt_e (
    .clk(ext_clk_i), .rst_n(rst_ni), .tick(tick_e), .ld(e_ld), .ld_val(e_val),
    .period(period_q), .cnt(cnt_e), .hit(hit_e)
  );

  always_ff @(posedge ext_clk_i or negedge rst_ni) begin
    if (!rst_ni)    mt_e <= 1'b0;
    else if (hit_e) mt_e <= ~mt_e;
  end

  tmr_sync2 #(.W(1)) u_match_sync (.clk(clk_i), .rst_n(rst_ni), .d(mt_e), .q(mt_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mt_d <= 1'b0;
    else         mt_d <= mt_s;
  end
  assign hit_x = mt_s ^ mt_d;

  // sticky match flag, set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (hit_b || hit_x)  flag_q <= 1'b1;
    else if (clr_flag)        flag_q <= 1'b0;
  end
  assign match_o = flag_q;

  // read path
  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[B_ON]            = on_q;
    ctrl_rd[B_FRZ]           = frz_q;
    ctrl_rd[B_SIDL]          = sidl_q;
    ctrl_rd[B_WDIS]          = wdis_q;
    ctrl_rd[B_TWIP]          = busy && async_mode;
    ctrl_rd[B_PS_LO +: 2]    = ckps_q;
    ctrl_rd[B_SYNC]          = sync_q;
    ctrl_rd[B_CS]            = cs_q;
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:   bus_rdata_o = ctrl_rd;
      A_COUNT:  bus_rdata_o = {{PADW{1'b0}}, (async_mode ? cnt_e : cnt_b)};
      A_PERIOD: bus_rdata_o = {{PADW{1'b0}}, period_q};
      default:  bus_rdata_o = {31'd0, flag_q};
    endcase
  end

  AST_FREEZE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && dbg_i) |-> !tick_b); // R3
  AST_FREEZE_NEEDS_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_i) |=> !frz_q); // R3
  AST_IDLE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sidl_q && idle_i) |-> !tick_b); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !clr_flag) |=> match_o); // R6
  AST_SYNC_NO_TWIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_mode) |-> !ctrl_rd[B_TWIP]); // R12
endmodule

// File: tb/hs_timer_bench.sv
module hs_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        dbg = 1'b0;
  logic        idle = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        match;

  int vec = 0;
  int fail = 0;

  always #5ns clk = ~clk;

  hs_timer u_hs_timer (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .dbg_i(dbg), .idle_i(idle),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .match_o(match)
  );

  localparam logic [1:0] RC = 2'd0, RN = 2'd1, RP = 2'd2, RS = 2'd3;

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    repeat (n) begin
      ext_clk = 1'b1; wait_clk(3);
      ext_clk = 1'b0; wait_clk(3);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int ratio(input int ps);
    return (ps == 3) ? 256 : (1 << (3 * ps));
  endfunction

  // stop, clear count and flag, set period, then start with given control
  task automatic start_run(input logic [31:0] period, input logic [31:0] ctrl);
    bwrite(RC, 32'h0);
    bwrite(RS, 32'h1);
    bwrite(RP, period);
    bwrite(RN, 32'h0);
    bwrite(RC, ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail++;
    $display("FAIL watchdog all-requirements act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end

  initial begin
    logic [31:0] d, c0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    bread(RC, d); chk("R1 ctrl", d, 32'h0);
    bread(RN, d); chk("R1 count", d, 32'h0);
    bread(RP, d); chk("R1 period", d, 32'h0000_FFFF);
    bread(RS, d); chk("R1 status", d, 32'h0);
    chk("R1 match_o", {31'd0, match}, 32'h0);

    // R2 reserved and read-only bits
    bwrite(RC, 32'hFFFF_FFFF);
    bread(RC, d); chk("R2 all-ones", d, 32'h0000_B036);
    bwrite(RC, 32'h0);
    bread(RC, d); chk("R2 clear", d, 32'h0);

    // R5 disabled holds, enabled counts
    start_run(32'hFFFF, 32'h0);
    wait_clk(10);
    bread(RN, d); chk("R5 disabled holds", d, 32'h0);
    for (int k = 0; k < 12; k++) begin
      start_run(32'hFFFF, 32'h8000);
      wait_clk(k);
      bread(RN, d); chk("R5 count after k", d, k);
    end

    // R7 prescale sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int j = 0; j < 5; j++) begin
        int dv, k;
        dv = ratio(ps);
        case (j)
          0: k = dv - 1;
          1: k = dv;
          2: k = dv + 1;
          3: k = 2 * dv + 3;
          default: k = 3 * dv - 1;
        endcase
        start_run(32'hFFFF, 32'h8000 | (ps << 4));
        wait_clk(k);
        bread(RN, d); chk("R7 prescaled count", d, k / dv);
      end
    end

    // R6 period wrap and sticky flag
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < 21; k++) begin
        start_run(p, 32'h8000);
        wait_clk(k);
        bread(RN, d); chk("R6 wrapped count", d, k % (p + 1));
        bread(RS, d); chk("R6 flag", d, (k >= p + 1) ? 1 : 0);
      end
    end
    bwrite(RC, 32'h0);
    bread(RS, d); chk("R6 flag stays when stopped", d, 32'h1);
    bwrite(RS, 32'h0);
    bread(RS, d); chk("R6 write 0 keeps flag", d, 32'h1);
    bwrite(RS, 32'h1);
    bread(RS, d); chk("R6 write 1 clears flag", d, 32'h0);

    // R3 freeze
    dbg = 1'b0;
    start_run(32'hFFFF, 32'hC000);
    bread(RC, d); chk("R3 freeze refused outside debug", d, 32'h8000);
    dbg = 1'b1;
    start_run(32'hFFFF, 32'hC000);
    bread(RC, d); chk("R3 freeze taken in debug", d, 32'hC000);
    wait_clk(10);
    bread(RN, d); chk("R3 frozen count", d, 32'h0);
    dbg = 1'b0;
    wait_clk(1);
    bread(RC, d); chk("R3 freeze forced low", d, 32'h8000);
    bread(RN, c0);
    wait_clk(5);
    bread(RN, d); chk("R3 resumes", d, c0 + 5);

    // R4 stop in idle
    idle = 1'b1;
    start_run(32'hFFFF, 32'hA000);
    wait_clk(10);
    bread(RN, d); chk("R4 idle halts", d, 32'h0);
    idle = 1'b0;
    bread(RN, c0);
    wait_clk(6);
    bread(RN, d); chk("R4 resumes after idle", d, c0 + 6);
    idle = 1'b1;
    start_run(32'hFFFF, 32'h8000);
    wait_clk(7);
    bread(RN, d); chk("R4 idle ignored without stop bit", d, 32'd7);
    idle = 1'b0;

    // R8 synchronised external clock
    for (int n = 0; n < 6; n++) begin
      start_run(32'hFFFF, 32'h8006);
      ext_pulses(n);
      wait_clk(4);
      bread(RN, d); chk("R8 ext edges counted", d, n);
    end
    start_run(32'hFFFF, 32'h8016);
    ext_pulses(17);
    wait_clk(4);
    bread(RN, d); chk("R8 ext edges prescaled by 8", d, 32'd2);

    // R12 synchronous writes immediate, lockout has no effect
    bwrite(RC, 32'h1006);
    bwrite(RN, 32'h1234);
    bread(RN, d); chk("R12 immediate load", d, 32'h1234);
    bread(RC, d); chk("R12 twip low", d, 32'h1006);
    bwrite(RN, 32'h0055);
    bread(RN, d); chk("R12 back-to-back accepted", d, 32'h0055);

    // R9 asynchronous write handshake
    bwrite(RC, 32'h0002);
    bwrite(RN, 32'hBEEF);
    bread(RC, d); chk("R9 twip set on write", d, 32'h0802);
    wait_clk(20);
    bread(RC, d); chk("R9 twip held without ext clock", d, 32'h0802);
    bread(RN, d); chk("R9 count unchanged while pending", d, 32'h0);
    ext_pulses(4);
    wait_clk(6);
    bread(RC, d); chk("R9 twip clears", d, 32'h0002);
    bread(RN, d); chk("R9 value applied", d, 32'hBEEF);

    // R10 lockout drops writes while pending
    bwrite(RC, 32'h1002);
    bwrite(RN, 32'h1111);
    bwrite(RN, 32'h2222);
    bread(RC, d); chk("R10 pending", d, 32'h1802);
    ext_pulses(8);
    wait_clk(6);
    bread(RN, d); chk("R10 second write dropped", d, 32'h1111);
    bread(RC, d); chk("R10 twip clears", d, 32'h1002);

    // R11 back-to-back, last value wins
    bwrite(RC, 32'h0002);
    bwrite(RN, 32'h3333);
    bwrite(RN, 32'h4444);
    bwrite(RN, 32'h5555);
    ext_pulses(10);
    wait_clk(6);
    bread(RN, d); chk("R11 last value applied", d, 32'h5555);
    bread(RC, d); chk("R11 twip clears", d, 32'h0002);

    // R13 asynchronous counting and match
    bwrite(RP, 32'hFFFF);
    bwrite(RC, 32'h8002);
    ext_pulses(3);
    bread(RN, c0);
    ext_pulses(7);
    wait_clk(2);
    bread(RN, d); chk("R13 ext-clocked count", d, c0 + 7);
    bwrite(RC, 32'h0002);
    bwrite(RN, 32'h0);
    ext_pulses(5);
    wait_clk(6);
    bread(RN, d); chk("R13 count reloaded", d, 32'h0);
    bwrite(RP, 32'h2);
    bwrite(RS, 32'h1);
    bread(RS, d); chk("R13 flag clear before run", d, 32'h0);
    bwrite(RC, 32'h8002);
    ext_pulses(10);
    wait_clk(6);
    bread(RS, d); chk("R13 async match sets flag", d, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end
endmodule